// File: doc/BRIEF.md
# Sliding-Window Linear Classifier Score Accumulator

This block scores every position of a fixed-size detection window over a frame of cell feature vectors, without ever storing the features. Cells arrive one at a time in column-major order: rows advance fastest, then columns. Each cell carries a 36-element descriptor. The block multiplies that descriptor by the classifier weights for every window position that covers the cell. Each product is added into a running partial score for that window. The descriptor is then dropped. A window covers 16 cell rows by 8 cell columns, so one cell reaches up to 128 windows, and it lands at a different offset in each of them.

The partial scores sit in a small buffer. The buffer holds one row of window scores for each of the last eight cell columns. When the bottom-right cell of a window has been added, the window's final score is compared with a programmable threshold. If it passes, the block emits a one-cycle detection that carries the window's top-left cell coordinates and its score. A write port fills the 4,608-entry weight store before a frame begins. Inside the block, 32 multiply-accumulate lanes cover 16 window rows and 2 window columns at once. A cell therefore takes 4 column phases of 18 steps each.

Top module: `svm_window_accum`

## Requirements
- R1: After reset, `feat_ready` is high and `det_valid` is low.
- R2: A cell is accepted on a clock edge where `feat_valid` and `feat_ready` are both high. `feat_ready` then stays low for exactly 72 cycles, one for each of the 4 column phases times 18 feature-pair steps.
- R3: A weight write stores `wload_data` at linear index `(wrow*8 + wcol)*36 + f`. Here `wrow` (0..15) and `wcol` (0..7) give the cell's offset inside the window, and `f` (0..35) is the descriptor element. Indices of 4,608 and above are not allowed.
- R4: Feature element `f` occupies `feat_data[f*9 +: 9]`. It is an unsigned fraction with 9 fraction bits. Weights are signed two's complement with 3 fraction bits. Scores are signed with 13 fraction bits. Each cell therefore adds twice the integer dot product of feature codes and weight codes to a window's score.
- R5: A window's score is updated once per covering cell, in arrival order. Each update saturates to the range -65536..65535.
- R6: A window's score starts from zero when its top-left cell arrives. Nothing carries over from earlier windows or earlier frames that used the same buffer slot.
- R7: A window is reported only if its final score, read as a signed value, is greater than or equal to `threshold`.
- R8: Only windows that lie wholly inside the frame are reported. `det_row` is at most FRAME_ROWS-16 and `det_col` is at most FRAME_COLS-8.
- R9: `det_valid` is a single-cycle pulse. It rises in the cycle `feat_ready` returns high after the window's bottom-right cell was accepted. Reports come in order of bottom-right cell arrival.
- R10: Cell positions are counted internally. The row advances first, and the column advances after row FRAME_ROWS-1. After the last cell of the frame, counting wraps to row 0, column 0 for the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wload_en | input | 1 | Weight write strobe |
| wload_addr | input | 13 | Linear weight index (R3) |
| wload_data | input | 4 | Signed weight code |
| threshold | input | 17 | Signed detection threshold |
| feat_valid | input | 1 | Cell descriptor offered |
| feat_ready | output | 1 | Block is idle and will take a cell |
| feat_data | input | 324 | 36 unsigned 9-bit descriptor elements |
| det_valid | output | 1 | Detection pulse |
| det_row | output | 5 | Window top-left cell row |
| det_col | output | 4 | Window top-left cell column |
| det_score | output | 17 | Final window score |

## Verification
The assertions assume four things about the inputs. The weight store is fully written before any cell is offered. Every load address is below 4,608. The threshold compared against a score is the value present in the cycle before the report. Descriptors are taken only at the accepting edge. The stimulus respects all four. It writes all 4,608 weights before streaming each frame. It holds the threshold fixed for a whole frame. It changes `feat_data` only while offering a new cell. Descriptor codes stay in the 9-bit range, with some frames using full-scale codes so that scores saturate in both directions.

// File: rtl/svm_acc_pkg.sv
package svm_acc_pkg;
    typedef enum logic {
        SVM_IDLE = 1'b0,
        SVM_RUN  = 1'b1
    } svm_state_e;
endpackage

// File: rtl/svm_weight_store.sv
module svm_weight_store #(
    parameter int WIN_ROWS  = 16,
    parameter int WIN_COLS  = 8,
    parameter int FEAT_DIM  = 36,
    parameter int WT_W      = 4,
    parameter int COL_LANES = 2,
    localparam int TOTAL    = WIN_ROWS * WIN_COLS * FEAT_DIM,
    localparam int WA_W     = $clog2(TOTAL),
    localparam int STEPS    = FEAT_DIM / 2,
    localparam int PHASES   = WIN_COLS / COL_LANES,
    localparam int WDEPTH   = PHASES * STEPS,
    localparam int DA_W     = $clog2(WDEPTH),
    localparam int WORD_W   = WIN_ROWS * COL_LANES * 2 * WT_W,
    localparam int BP_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wload_en,
    input  logic [WA_W-1:0]   wload_addr,
    input  logic [WT_W-1:0]   wload_data,
    input  logic [DA_W-1:0]   rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [WDEPTH];
    logic [DA_W-1:0]   word_d;
    logic [BP_W-1:0]   bit_d;
    logic              wr_ok_d;

    // Decode linear index into (phase,step) word and lane/term bit slot.
    always_comb begin
        int idx, wrow, wcol, f, lane;
        idx     = int'(wload_addr);
        wrow    = idx / (WIN_COLS * FEAT_DIM);
        wcol    = (idx / FEAT_DIM) % WIN_COLS;
        f       = idx % FEAT_DIM;
        lane    = (wcol % COL_LANES) * WIN_ROWS + wrow;
        word_d  = DA_W'((wcol / COL_LANES) * STEPS + f / 2);
        bit_d   = BP_W'((lane * 2 + (f % 2)) * WT_W);
        wr_ok_d = wload_en && (idx < TOTAL);
    end

    always_ff @(posedge clk) begin
        if (wr_ok_d) begin
            mem[word_d][bit_d +: WT_W] <= wload_data;
        end
    end

    assign rd_word = mem[rd_addr];

    assert_load_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wload_en |-> (wload_addr < WA_W'(TOTAL)));
endmodule

// File: rtl/svm_mac_lane.sv
module svm_mac_lane #(
    parameter int FEAT_W = 9,
    parameter int WT_W   = 4,
    parameter int DOT_W  = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic                    first,
    input  logic [FEAT_W-1:0]       feat_a,
    input  logic [FEAT_W-1:0]       feat_b,
    input  logic signed [WT_W-1:0]  wt_a,
    input  logic signed [WT_W-1:0]  wt_b,
    output logic signed [DOT_W-1:0] dot_d
);
    logic signed [DOT_W-1:0] dot_q;
    logic signed [DOT_W-1:0] fa, fb, wa, wb, base;

    always_comb begin
        fa    = $signed(DOT_W'(feat_a));
        fb    = $signed(DOT_W'(feat_b));
        wa    = DOT_W'(wt_a);
        wb    = DOT_W'(wt_b);
        base  = first ? '0 : dot_q;
        dot_d = base + fa * wa + fb * wb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dot_q <= '0;
        end else if (step_en) begin
            dot_q <= dot_d;
        end
    end
endmodule

// File: rtl/svm_window_accum.sv
module svm_window_accum
    import svm_acc_pkg::*;
#(
    parameter int FEAT_W     = 9,
    parameter int FEAT_DIM   = 36,
    parameter int WT_W       = 4,
    parameter int ACC_W      = 17,
    parameter int ALIGN      = 1,
    parameter int WIN_ROWS   = 16,
    parameter int WIN_COLS   = 8,
    parameter int COL_LANES  = 2,
    parameter int FRAME_ROWS = 18,
    parameter int FRAME_COLS = 10,
    localparam int TOTAL     = WIN_ROWS * WIN_COLS * FEAT_DIM,
    localparam int WA_W      = $clog2(TOTAL),
    localparam int ROW_W     = $clog2(FRAME_ROWS),
    localparam int COL_W     = $clog2(FRAME_COLS),
    localparam int FD_W      = FEAT_DIM * FEAT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wload_en,
    input  logic [WA_W-1:0]         wload_addr,
    input  logic [WT_W-1:0]         wload_data,
    input  logic signed [ACC_W-1:0] threshold,
    input  logic                    feat_valid,
    output logic                    feat_ready,
    input  logic [FD_W-1:0]         feat_data,
    output logic                    det_valid,
    output logic [ROW_W-1:0]        det_row,
    output logic [COL_W-1:0]        det_col,
    output logic signed [ACC_W-1:0] det_score
);
    localparam int STEPS  = FEAT_DIM / 2;
    localparam int PHASES = WIN_COLS / COL_LANES;
    localparam int LANES  = WIN_ROWS * COL_LANES;
    localparam int WDEPTH = PHASES * STEPS;
    localparam int DA_W   = $clog2(WDEPTH);
    localparam int WORD_W = LANES * 2 * WT_W;
    localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int ST_W   = $clog2(STEPS);
    localparam int NWR    = FRAME_ROWS - WIN_ROWS + 1;
    localparam int NWC    = FRAME_COLS - WIN_COLS + 1;
    localparam int SLOT_W = (WIN_COLS > 1) ? $clog2(WIN_COLS) : 1;
    localparam int WRI_W  = (NWR > 1) ? $clog2(NWR) : 1;
    localparam int DOT_W  = FEAT_W + WT_W + 1 + $clog2(FEAT_DIM);
    localparam int SUM_W  = DOT_W + ALIGN + ACC_W;
    localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] S_MIN = -(SUM_W'(2 ** (ACC_W - 1)));
    localparam logic [ROW_W-1:0] LAST_WR = ROW_W'(NWR - 1);
    localparam logic [COL_W-1:0] LAST_WC = COL_W'(NWC - 1);

    typedef struct packed {
        svm_state_e              st;
        logic [PH_W-1:0]         phase;
        logic [ST_W-1:0]         step;
        logic [ROW_W-1:0]        row;
        logic [COL_W-1:0]        col;
        logic [FD_W-1:0]         feat;
        logic                    det_valid;
        logic [ROW_W-1:0]        det_row;
        logic [COL_W-1:0]        det_col;
        logic signed [ACC_W-1:0] det_score;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic signed [ACC_W-1:0] scores_d [WIN_COLS][NWR];
    logic signed [ACC_W-1:0] scores_q [WIN_COLS][NWR];

    logic [DA_W-1:0]         rd_addr;
    logic [WORD_W-1:0]       wt_word;
    logic [FEAT_W-1:0]       feat_a, feat_b;
    logic                    run, first_step, last_step;
    logic signed [DOT_W-1:0] lane_dot [LANES];

    function automatic logic signed [ACC_W-1:0] sat_acc(
        input logic signed [ACC_W-1:0] a,
        input logic signed [DOT_W-1:0] d
    );
        logic signed [SUM_W-1:0] s;
        s = SUM_W'(a) + (SUM_W'(d) <<< ALIGN);
        if (s > S_MAX) s = S_MAX;
        if (s < S_MIN) s = S_MIN;
        return ACC_W'(s);
    endfunction

    assign run        = (ctl_q.st == SVM_RUN);
    assign first_step = (ctl_q.step == '0);
    assign last_step  = (ctl_q.step == ST_W'(STEPS - 1));
    assign rd_addr    = DA_W'(int'(ctl_q.phase) * STEPS + int'(ctl_q.step));
    assign feat_a     = ctl_q.feat[(2 * int'(ctl_q.step)) * FEAT_W +: FEAT_W];
    assign feat_b     = ctl_q.feat[(2 * int'(ctl_q.step) + 1) * FEAT_W +: FEAT_W];

    svm_weight_store #(
        .WIN_ROWS (WIN_ROWS),
        .WIN_COLS (WIN_COLS),
        .FEAT_DIM (FEAT_DIM),
        .WT_W     (WT_W),
        .COL_LANES(COL_LANES)
    ) wstore_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wload_en  (wload_en),
        .wload_addr(wload_addr),
        .wload_data(wload_data),
        .rd_addr   (rd_addr),
        .rd_word   (wt_word)
    );

    // One lane per (window row offset, window column within the pair).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        svm_mac_lane #(
            .FEAT_W(FEAT_W),
            .WT_W  (WT_W),
            .DOT_W (DOT_W)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_en(run),
            .first  (first_step),
            .feat_a (feat_a),
            .feat_b (feat_b),
            .wt_a   (wt_word[(2 * g) * WT_W +: WT_W]),
            .wt_b   (wt_word[(2 * g + 1) * WT_W +: WT_W]),
            .dot_d  (lane_dot[g])
        );
    end

    always_comb begin
        int dc, wr, wc;
        logic [SLOT_W-1:0]       slot;
        logic [WRI_W-1:0]        wri;
        logic signed [ACC_W-1:0] old_v, new_v;

        ctl_d           = ctl_q;
        ctl_d.det_valid = 1'b0;
        scores_d        = scores_q;

        case (ctl_q.st)
            SVM_IDLE: begin
                if (feat_valid) begin
                    ctl_d.st    = SVM_RUN;
                    ctl_d.feat  = feat_data;
                    ctl_d.phase = '0;
                    ctl_d.step  = '0;
                end
            end
            default: begin
                if (last_step) begin
                    // Fold the finished lane sums into their window scores.
                    for (int lc = 0; lc < COL_LANES; lc++) begin
                        for (int dr = 0; dr < WIN_ROWS; dr++) begin
                            dc = int'(ctl_q.phase) * COL_LANES + lc;
                            wr = int'(ctl_q.row) - dr;
                            wc = int'(ctl_q.col) - dc;
                            if (wr >= 0 && wr < NWR && wc >= 0 && wc < NWC) begin
                                slot  = SLOT_W'(wc % WIN_COLS);
                                wri   = WRI_W'(wr);
                                old_v = (dr == 0 && dc == 0) ? '0 : scores_q[slot][wri];
                                new_v = sat_acc(old_v, lane_dot[lc * WIN_ROWS + dr]);
                                scores_d[slot][wri] = new_v;
                                if (dr == WIN_ROWS - 1 && dc == WIN_COLS - 1 &&
                                    new_v >= threshold) begin
                                    ctl_d.det_valid = 1'b1;
                                    ctl_d.det_row   = ROW_W'(wr);
                                    ctl_d.det_col   = COL_W'(wc);
                                    ctl_d.det_score = new_v;
                                end
                            end
                        end
                    end
                    ctl_d.step = '0;
                    if (ctl_q.phase == PH_W'(PHASES - 1)) begin
                        ctl_d.st    = SVM_IDLE;
                        ctl_d.phase = '0;
                        if (ctl_q.row == ROW_W'(FRAME_ROWS - 1)) begin
                            ctl_d.row = '0;
                            ctl_d.col = (ctl_q.col == COL_W'(FRAME_COLS - 1)) ?
                                        '0 : ctl_q.col + 1'b1;
                        end else begin
                            ctl_d.row = ctl_q.row + 1'b1;
                        end
                    end else begin
                        ctl_d.phase = ctl_q.phase + 1'b1;
                    end
                end else begin
                    ctl_d.step = ctl_q.step + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int s = 0; s < WIN_COLS; s++) begin
                for (int r = 0; r < NWR; r++) begin
                    scores_q[s][r] <= '0;
                end
            end
        end else begin
            ctl_q    <= ctl_d;
            scores_q <= scores_d;
        end
    end

    assign feat_ready = (ctl_q.st == SVM_IDLE);
    assign det_valid  = ctl_q.det_valid;
    assign det_row    = ctl_q.det_row;
    assign det_col    = ctl_q.det_col;
    assign det_score  = ctl_q.det_score;

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_valid && feat_ready) |=> !feat_ready);

    assert_det_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |=> !det_valid);

    assert_det_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> feat_ready);

    assert_det_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> (det_row <= LAST_WR && det_col <= LAST_WC));

    assert_det_threshold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> (det_score >= $past(threshold)));
endmodule

// File: tb/svm_window_accum_tb_top.sv
module svm_window_accum_tb_top;
    localparam int FEAT_W = 9, FEAT_DIM = 36, WT_W = 4, ACC_W = 17;
    localparam int WIN_ROWS = 16, WIN_COLS = 8;
    localparam int FRAME_ROWS = 18, FRAME_COLS = 10;
    localparam int NWR = FRAME_ROWS - WIN_ROWS + 1;
    localparam int NWC = FRAME_COLS - WIN_COLS + 1;
    localparam int TOTAL = WIN_ROWS * WIN_COLS * FEAT_DIM;
    localparam int WA_W = $clog2(TOTAL);
    localparam int ROW_W = $clog2(FRAME_ROWS);
    localparam int COL_W = $clog2(FRAME_COLS);
    localparam int SMAX = 65535, SMIN = -65536;

    // Case table: threshold, data mode (0 random, 1 all +max, 2 all -min), seed.
    localparam int NCASE = 6;
    localparam int TC_THR  [NCASE] = '{SMIN, 0, SMIN, SMAX, SMIN, 3000};
    localparam int TC_MODE [NCASE] = '{0, 0, 0, 1, 2, 0};
    localparam int TC_SEED [NCASE] = '{1, 2, 2, 3, 4, 5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wload_en = 1'b0;
    logic [WA_W-1:0] wload_addr = '0;
    logic [WT_W-1:0] wload_data = '0;
    logic signed [ACC_W-1:0] threshold = '0;
    logic feat_valid = 1'b0;
    logic feat_ready;
    logic [FEAT_DIM*FEAT_W-1:0] feat_data = '0;
    logic det_valid;
    logic [ROW_W-1:0] det_row;
    logic [COL_W-1:0] det_col;
    logic signed [ACC_W-1:0] det_score;

    int checks = 0, fails = 0, cyc = 0, ndet = 0;
    int det_r [16];
    int det_c [16];
    int det_s [16];

    always #5 clk = ~clk;

    svm_window_accum dut_i (
        .clk(clk), .rst_n(rst_n), .wload_en(wload_en), .wload_addr(wload_addr),
        .wload_data(wload_data), .threshold(threshold), .feat_valid(feat_valid),
        .feat_ready(feat_ready), .feat_data(feat_data), .det_valid(det_valid),
        .det_row(det_row), .det_col(det_col), .det_score(det_score)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned hsh(input int unsigned a);
        int unsigned x;
        x = a * 32'd2654435761;
        x = x ^ (x >> 15);
        x = x * 32'd2246822519;
        x = x ^ (x >> 13);
        return x;
    endfunction

    function automatic int wt_of(input int idx, input int mode, input int seed);
        int v;
        if (mode == 1) return 7;
        if (mode == 2) return -8;
        v = int'(hsh(idx + seed * 40503) & 15);
        return (v > 7) ? v - 16 : v;
    endfunction

    function automatic int ft_of(input int r, input int c, input int f,
                                 input int mode, input int seed);
        if (mode != 0) return 511;
        return int'(hsh(((r * FRAME_COLS + c) * FEAT_DIM + f) ^ (seed << 20)) & 63);
    endfunction

    // R4 R5 R6: reference score summed in arrival order, saturating per cell.
    function automatic int ref_score(input int wr, input int wc, input int mode,
                                     input int seed);
        int acc, dot;
        acc = 0;
        for (int cc = 0; cc < WIN_COLS; cc++) begin
            for (int rr = 0; rr < WIN_ROWS; rr++) begin
                dot = 0;
                for (int f = 0; f < FEAT_DIM; f++) begin
                    dot += ft_of(wr + rr, wc + cc, f, mode, seed) *
                           wt_of((rr * WIN_COLS + cc) * FEAT_DIM + f, mode, seed);
                end
                acc = acc + 2 * dot;
                if (acc > SMAX) acc = SMAX;
                if (acc < SMIN) acc = SMIN;
            end
        end
        return acc;
    endfunction

    always @(negedge clk) begin
        if (det_valid) begin
            if (ndet < 16) begin
                det_r[ndet] = int'(det_row);
                det_c[ndet] = int'(det_col);
                det_s[ndet] = int'(det_score);
            end
            ndet++;
        end
    end

    task automatic load_weights(input int mode, input int seed);
        for (int i = 0; i < TOTAL; i++) begin
            @(negedge clk);
            wload_en   = 1'b1;
            wload_addr = WA_W'(i);
            wload_data = WT_W'(wt_of(i, mode, seed));
        end
        @(negedge clk);
        wload_en = 1'b0;
    endtask

    task automatic send_cell(input int r, input int c, input int mode, input int seed);
        @(negedge clk);
        while (!feat_ready) @(negedge clk);
        feat_valid = 1'b1;
        for (int f = 0; f < FEAT_DIM; f++) begin
            feat_data[f*FEAT_W +: FEAT_W] = FEAT_W'(ft_of(r, c, f, mode, seed));
        end
        @(negedge clk);
        feat_valid = 1'b0;
    endtask

    task automatic run_case(input int k, input bit time_ready);
        int mode, seed, thr, j, exp_n, sc, lowcnt;
        mode = TC_MODE[k];
        seed = TC_SEED[k];
        thr  = TC_THR[k];
        load_weights(mode, seed);
        threshold = ACC_W'(thr);
        ndet = 0;
        // R10: column-major cell order, rows fastest.
        for (int c = 0; c < FRAME_COLS; c++) begin
            for (int r = 0; r < FRAME_ROWS; r++) begin
                send_cell(r, c, mode, seed);
                if (time_ready && r == 0 && c == 0) begin
                    lowcnt = 0;
                    while (!feat_ready) begin
                        lowcnt++;
                        @(negedge clk);
                    end
                    chk(lowcnt == 72, "R2", "busy cycles after accept", lowcnt, 72);
                end
            end
        end
        @(negedge clk);
        while (!feat_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        // R7 R8 R9: expected reports in bottom-right-cell arrival order.
        exp_n = 0;
        j = 0;
        for (int wc = 0; wc < NWC; wc++) begin
            for (int wr = 0; wr < NWR; wr++) begin
                sc = ref_score(wr, wc, mode, seed);
                if (sc >= thr) begin
                    exp_n++;
                    if (j < ndet && j < 16) begin
                        chk(det_r[j] == wr, "R8", "window row", det_r[j], wr);
                        chk(det_c[j] == wc, "R8", "window col", det_c[j], wc);
                        chk(det_s[j] == sc, "R4 R5 R6", "window score", det_s[j], sc);
                    end
                    j++;
                end
            end
        end
        chk(ndet == exp_n, "R7", "detection count", ndet, exp_n);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(feat_ready == 1'b1, "R1", "feat_ready in reset", int'(feat_ready), 1);
        chk(det_valid == 1'b0, "R1", "det_valid in reset", int'(det_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(feat_ready == 1'b1, "R1", "feat_ready after reset", int'(feat_ready), 1);
        chk(det_valid == 1'b0, "R1", "det_valid after reset", int'(det_valid), 0);
        // R3 R4 R5 R6 R7: case table; case 2 repeats case 1 data to expose carry-over,
        // case 3 saturates high at threshold equality, case 4 saturates low.
        for (int k = 0; k < NCASE; k++) begin
            run_case(k, k == 0);
        end
        // R9: no stray pulse once the stream is idle.
        repeat (20) @(negedge clk);
        chk(det_valid == 1'b0, "R9", "det_valid while idle", int'(det_valid), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule